// File: doc/BRIEF.md
# Ethernet Receive Frame Packer

The block takes a received Ethernet frame as a stream of bytes, from the first destination address octet through the four frame check octets. It packs the stream into 32-bit words of an internal receive FIFO. Each stored frame begins with a header word whose low half carries the frame's byte count. The remaining bytes fill the word lanes from least significant to most significant, in the order they arrive. The byte count is known only when the frame ends. The block therefore reserves the header slot when the frame starts and writes the header into it afterwards. A reader sees the frame only once that header write is done.

A frame that does not fit in the FIFO is dropped completely. The write pointer returns to the frame's header slot and a sticky overflow flag is raised. A FIFO clear input empties the store and lowers the flag, but only while reception is disabled. Software is expected to drop the receive enable first and then request the clear. Bytes offered while reception is disabled are dropped. The sender must leave at least one idle cycle after a frame's last byte.

Top module: `eth_rx_packer`

## Requirements
- R1: The header word of a stored frame holds the frame's byte count in bits 15:0, low byte in bits 7:0 and high byte in bits 15:8. The count covers every byte received for the frame, check octets included.
- R2: The first two frame bytes sit in bits 23:16 and 31:24 of the header word. Every later byte fills lanes 7:0, 15:8, 23:16, 31:24 of the following words in arrival order. The last four bytes, the check octets, are stored as the frame's final bytes.
- R3: Unused upper lanes of a frame's last word read as zero. This includes the header word of a frame shorter than two bytes.
- R4: After the edge that takes a frame's last byte, rd_valid stays low for one more cycle while the header is written. It rises after the following edge.
- R5: A frame that needs a word slot while the FIFO holds 2^ADDR_W words is discarded entirely. overflow goes high and stays high until a clear is honoured. Frames committed earlier stay readable and unchanged.
- R6: A byte offered while rx_enable is low is not stored and is not counted in the frame length.
- R7: fifo_clear taken while rx_enable is low empties the FIFO and lowers overflow by the next cycle. While rx_enable is high, fifo_clear has no effect on stored words or on overflow.
- R8: After reset, rd_valid and overflow are low.
- R9: A byte offered in the cycle right after a frame's last byte is ignored.
- R10: Words are read in the order they were stored, across several frames. A read with rd_en high advances by one word. rd_valid falls once every committed word has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receive enable; bytes are taken only while high |
| fifo_clear | input | 1 | Clear request, honoured only while rx_enable is low |
| in_valid | input | 1 | A frame byte is offered this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | The offered byte is the frame's last |
| rd_en | input | 1 | Pop the word on rd_data |
| rd_data | output | 32 | Oldest committed word |
| rd_valid | output | 1 | At least one committed word is waiting |
| overflow | output | 1 | Sticky: a frame was dropped for lack of room |

## Verification
The packing path is swept over every frame length from 1 to 40 bytes, with byte values that depend on both length and position. This exercises every final-lane position and exposes swapped lanes, wrong header offsets and stale upper lanes. Several differently sized frames are then queued back to back before any read, which separates correct pointer commit and read order from behaviour that only works on an empty FIFO. Disabling reception in the middle of a frame, and placing a stray byte just after a frame's end, check that ignored bytes leave no trace in either the data or the count. A fill-until-overflow sequence, followed by clear requests with reception enabled and then disabled, shows the rewind, the sticky flag and the gating of the clear.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LEN_W  = 16;
    localparam int HDR_BYTES = (WORD_W - LEN_W) / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_PATCH,
        ST_DROP
    } rx_state_e;
endpackage

// File: rtl/eth_rx_lane_acc.sv
module eth_rx_lane_acc #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int WORD_W = BYTE_W * LANES,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_en,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [LANE_W-1:0] lane,
    output logic [WORD_W-1:0] word_out
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
    } acc_regs_t;

    acc_regs_t q, d;
    logic [WORD_W-1:0] merged;

    always_comb begin
        d = q;
        // lane 0 opens a fresh word, so older lanes are zero-filled
        merged = (lane == '0) ? '0 : q.acc;
        for (int g = 0; g < LANES; g++) begin
            if (lane == LANE_W'(g)) begin
                merged[g*BYTE_W +: BYTE_W] = byte_in;
            end
        end
        if (byte_en) begin
            d.acc = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_out = merged;

    generate
        if (LANES > 2) begin : g_zero_chk
            // R3: the second byte of a word finds the upper lanes still clear
            p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (byte_en && lane == LANE_W'(1)) |-> (word_out[WORD_W-1:2*BYTE_W] == '0));
        end
    endgenerate
endmodule

// File: rtl/eth_rx_word_ram.sv
module eth_rx_word_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eth_rx_packer.sv
module eth_rx_packer
    import eth_rx_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int PTR_W = ADDR_W + 1,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              fifo_clear,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              overflow
);
    typedef struct packed {
        rx_state_e                   st;
        logic [LEN_W-1:0]            cnt;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            base;
        logic [PTR_W-1:0]            commit;
        logic [PTR_W-1:0]            rd;
        logic [HDR_BYTES*BYTE_W-1:0] hdr_hi;
        logic                        ovf;
    } regs_t;

    regs_t q, d;

    logic              take;
    logic              clear_ok;
    logic              full;
    logic [PTR_W-1:0]  used;
    logic [LANE_W-1:0] lane;
    logic              acc_en;
    logic [WORD_W-1:0] acc_word;
    logic              wen;
    logic [ADDR_W-1:0] waddr;
    logic [WORD_W-1:0] wdata;

    assign take     = in_valid && rx_enable && (q.st != ST_PATCH);
    assign clear_ok = fifo_clear && !rx_enable;
    assign used     = q.wr - q.rd;
    assign full     = (used == PTR_W'(DEPTH));
    // frame byte n sits at stream offset n + 2 behind the length field
    assign lane     = q.cnt[LANE_W-1:0] + LANE_W'(2);
    assign acc_en   = take && (q.st == ST_BODY) && (q.cnt >= LEN_W'(HDR_BYTES));

    eth_rx_lane_acc #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_en  (acc_en),
        .byte_in  (in_data),
        .lane     (lane),
        .word_out (acc_word)
    );

    always_comb begin
        d     = q;
        wen   = 1'b0;
        waddr = q.wr[ADDR_W-1:0];
        wdata = acc_word;

        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.cnt    = LEN_W'(1);
                    d.hdr_hi = {{BYTE_W{1'b0}}, in_data};
                    d.base   = q.wr;
                    if (full) begin
                        d.ovf = 1'b1;
                        d.st  = in_last ? ST_IDLE : ST_DROP;
                    end else begin
                        d.wr = q.wr + PTR_W'(1);
                        d.st = in_last ? ST_PATCH : ST_BODY;
                    end
                end
            end
            ST_BODY: begin
                if (take) begin
                    d.cnt = q.cnt + LEN_W'(1);
                    if (q.cnt < LEN_W'(HDR_BYTES)) begin
                        d.hdr_hi[BYTE_W +: BYTE_W] = in_data;
                        if (in_last) begin
                            d.st = ST_PATCH;
                        end
                    end else if (lane == LANE_W'(LANES - 1) || in_last) begin
                        if (full) begin
                            d.ovf = 1'b1;
                            d.wr  = q.base;
                            d.st  = in_last ? ST_IDLE : ST_DROP;
                        end else begin
                            wen  = 1'b1;
                            d.wr = q.wr + PTR_W'(1);
                            if (in_last) begin
                                d.st = ST_PATCH;
                            end
                        end
                    end
                end
            end
            ST_PATCH: begin
                wen      = 1'b1;
                waddr    = q.base[ADDR_W-1:0];
                wdata    = {q.hdr_hi, q.cnt};
                d.commit = q.wr;
                d.st     = ST_IDLE;
            end
            ST_DROP: begin
                if (take && in_last) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (rd_en && (q.rd != q.commit)) begin
            d.rd = q.rd + PTR_W'(1);
        end

        if (clear_ok) begin
            d.st     = ST_IDLE;
            d.wr     = '0;
            d.base   = '0;
            d.commit = '0;
            d.rd     = '0;
            d.ovf    = 1'b0;
            wen      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    eth_rx_word_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (wen),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (q.rd[ADDR_W-1:0]),
        .rdata (rd_data)
    );

    assign rd_valid = (q.rd != q.commit);
    assign overflow = q.ovf;

    // R4: the commit pointer only moves out of the header-write state
    p_commit_after_patch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.commit != $past(q.commit) && !$past(clear_ok)) |-> ($past(q.st) == ST_PATCH));

    // R5: the overflow flag survives until a clear is honoured
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !clear_ok) |=> q.ovf);

    // R5: committed words never exceed the storage
    p_no_overfill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.commit - q.rd) <= PTR_W'(DEPTH));

    // R6: nothing is stored from a disabled receiver outside the header write
    p_no_store_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && q.st != ST_PATCH) |-> !wen);

    // R7: an honoured clear leaves an empty FIFO and a low flag
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_ok |=> (!rd_valid && !overflow));
endmodule

// File: tb/eth_rx_packer_bench.sv
`timescale 1ns/1ps
module eth_rx_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0;
    logic        fifo_clear = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        overflow;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_q [$];
    logic [7:0]  fb [0:63];

    always #2.5 clk = ~clk;

    eth_rx_packer #(.ADDR_W(4)) u_eth_rx_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_enable  (rx_enable),
        .fifo_clear (fifo_clear),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .overflow   (overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 1);
    endfunction

    // expected words from fb[0..len-1]: header then lanes from offset 2
    task automatic model_frame(input int len);
        int nw;
        logic [31:0] w [0:16];
        nw = (len <= 2) ? 1 : 1 + (len - 2 + 3) / 4;
        for (int k = 0; k < nw; k++) w[k] = '0;
        w[0][15:0] = 16'(len);
        for (int i = 0; i < len; i++) begin
            w[(i + 2) / 4][((i + 2) % 4) * 8 +: 8] = fb[i];
        end
        for (int k = 0; k < nw; k++) exp_q.push_back(w[k]);
    endtask

    task automatic send_frame(input int len, input int seed, input bit chk_vis, input bit stray, input bit keep);
        for (int i = 0; i < len; i++) fb[i] = byte_of(seed, i);
        if (keep) model_frame(len);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = fb[i];
            in_last  = (i == len - 1);
            @(negedge clk);
        end
        if (chk_vis) check(rd_valid == 1'b0, "R4 hidden during header write", 32'(rd_valid), 0);
        if (stray) begin
            in_valid = 1'b1; in_data = 8'hEE; in_last = 1'b1;
        end else begin
            in_valid = 1'b0; in_last = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (chk_vis) check(rd_valid == 1'b1, "R4 visible after header write", 32'(rd_valid), 1);
    endtask

    task automatic drain(input string tag);
        logic [31:0] e;
        rd_en = 1'b0;
        @(negedge clk);
        while (rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, tag, rd_data, 32'h0);
            end else begin
                e = exp_q.pop_front();
                check(rd_data === e, tag, rd_data, e);
            end
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        check(exp_q.size() == 0, "R10 all words delivered", 32'(exp_q.size()), 0);
    endtask

    task automatic do_clear();
        rx_enable = 1'b0; fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0; rx_enable = 1'b1;
        exp_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R8 rd_valid after reset", 32'(rd_valid), 0);
        check(overflow == 1'b0, "R8 overflow after reset", 32'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_enable = 1'b1;

        // R1 R2 R3 R4: every length 1..40 through an empty FIFO
        for (int len = 1; len <= 40; len++) begin
            send_frame(len, len, 1'b1, 1'b0, 1'b1);
            drain("R1 R2 R3 packed words");
        end

        // R10: several frames queued before reading
        send_frame(3, 101, 1'b0, 1'b0, 1'b1);
        send_frame(9, 102, 1'b0, 1'b0, 1'b1);
        send_frame(14, 103, 1'b0, 1'b0, 1'b1);
        drain("R10 multi-frame order");

        // R9: stray byte right after a frame end
        send_frame(7, 55, 1'b0, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        drain("R9 stray byte ignored");

        // R6: receiver disabled for bytes 3..5 of a ten-byte burst
        begin
            int kept;
            kept = 0;
            for (int i = 0; i < 10; i++) begin
                rx_enable = !(i >= 3 && i <= 5);
                in_valid  = 1'b1;
                in_data   = byte_of(77, i);
                in_last   = (i == 9);
                if (rx_enable) begin fb[kept] = in_data; kept++; end
                @(negedge clk);
            end
            in_valid = 1'b0; in_last = 1'b0; rx_enable = 1'b1;
            model_frame(kept);
            @(negedge clk);
            drain("R6 disabled bytes dropped");
        end

        // R6: whole frame while disabled leaves nothing
        rx_enable = 1'b0;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; in_data = 8'(i); in_last = (i == 5);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (2) @(negedge clk);
        check(rd_valid == 1'b0, "R6 nothing stored while disabled", 32'(rd_valid), 0);
        rx_enable = 1'b1;

        // R5: two 20-byte frames take 12 words, a third cannot fit
        do_clear();
        send_frame(20, 201, 1'b0, 1'b0, 1'b1);
        send_frame(20, 202, 1'b0, 1'b0, 1'b1);
        check(overflow == 1'b0, "R5 no overflow while fitting", 32'(overflow), 0);
        send_frame(20, 203, 1'b0, 1'b0, 1'b0);
        check(overflow == 1'b1, "R5 overflow raised", 32'(overflow), 1);
        send_frame(5, 204, 1'b0, 1'b0, 1'b1);
        check(overflow == 1'b1, "R5 overflow sticky", 32'(overflow), 1);

        // R7: clear with receiver enabled is ignored
        fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        @(negedge clk);
        check(overflow == 1'b1, "R7 clear ignored while enabled", 32'(overflow), 1);
        drain("R5 R7 earlier frames intact");

        // R7: honoured clear drops queued content and the flag
        send_frame(11, 300, 1'b0, 1'b0, 1'b0);
        rx_enable = 1'b0; fifo_clear = 1'b1;
        @(negedge clk);
        fifo_clear = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R7 empty after clear", 32'(rd_valid), 0);
        check(overflow == 1'b0, "R7 overflow cleared", 32'(overflow), 0);
        rx_enable = 1'b1;
        send_frame(6, 301, 1'b0, 1'b0, 1'b1);
        drain("R7 fresh frame after clear");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule